// File: doc/BRIEF.md
# SWD Host Transaction Master

This block is the host end of a two-wire serial debug link. A single-cycle `start` pulse carries one command: a debug-port or access-port select, a read/write flag, a two-bit register address and, for writes, a 32-bit word. The block builds the eight-bit request frame and generates the serial clock from the system clock through a divider. It releases the data line for the park bit and for every turnaround. It then samples the target's three-bit acknowledge.

An OK acknowledge is followed by a 33-bit data phase. On a write the host drives that phase, and on a read it captures it. A WAIT acknowledge causes the same request to be sent again, up to a fixed number of extra attempts. FAULT and unknown codes end the transaction at once. The result appears on a one-cycle `done` strobe together with the acknowledge code, the read word and a read-parity error flag.

A second command type, selected by `cmd_line_reset`, puts the link back into a known state. It drives the line high for a long run of clocks and then low for a few idle clocks.

Top module: `swd_host`

## Requirements
- R1: A request frame is eight bit periods, sent first to last as: 1, port select (`cmd_ap`), `cmd_read`, `cmd_addr[0]`, `cmd_addr[1]`, even parity of those four fields, 0, and a final bit during which `swdio_oe` is low.
- R2: After the request comes one bit period with the line released. Then come three released bit periods in which the acknowledge is sampled, first bit into `done_ack[0]`. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R3: On a write with OK, one released bit period follows the acknowledge. The host then drives 33 bits: the write word least significant bit first, then the even parity of the word. The transaction ends after the last of these bits.
- R4: On a read with OK, 33 released bit periods are sampled as the read word (least significant bit first) followed by its parity bit. One more released bit period follows, and `done_rdata` carries the word.
- R5: `done_perr` is 1 exactly when a read with OK returned a parity bit different from the even parity of the returned word.
- R6: After a WAIT acknowledge and one released bit period, the request is sent again. At most RETRY_MAX repeats follow the first attempt. If the last attempt also gets WAIT, the transaction is reported with code WAIT.
- R7: After FAULT or any code other than OK or WAIT, one released bit period follows and the transaction ends with no data phase. It reports that code, `done_rdata` = 0 and `done_perr` = 0.
- R8: Each bit period is CLK_HALF system clocks with `swclk` low followed by CLK_HALF clocks with `swclk` high. `swdio_out` and `swdio_oe` change only while `swclk` is low, and `swclk` stays low when the block is not busy.
- R9: A line-reset command drives the line high for LRST_HIGH bit periods and then low for LRST_LOW bit periods. It ends with `done_ack` = 0, `done_rdata` = 0 and `done_perr` = 0.
- R10: When the block is not busy, the line is driven low and `busy` is low. `start` while busy has no effect. `done` is high for exactly one cycle, in the cycle after the last bit period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| cmd_ap | input | 1 | 1 selects access-port register, 0 debug-port register |
| cmd_read | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write word |
| cmd_line_reset | input | 1 | Command is a line reset instead of a transfer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| done_ack | output | 3 | Final acknowledge code |
| done_rdata | output | 32 | Read word (0 unless read with OK) |
| done_perr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial clock to the target |
| swdio_in | input | 1 | Serial data from the pad |
| swdio_out | output | 1 | Serial data to the pad |
| swdio_oe | output | 1 | Pad output enable |

## Verification
The bench targets the places where the line changes hands. A design that drove the park bit, or skipped or doubled a turnaround, would shift every later bit by one period, and the per-clock waveform comparison shows this at once. Retry handling is checked at both ends. A WAIT followed by OK must produce exactly one data phase. Continuous WAIT must stop after the configured repeat count; a design off by one sends one request too many or too few. Read parity is checked with a correct parity bit and with a corrupted one, and invalid acknowledge codes of all-ones and all-zeros are used. These would catch a design that treated anything other than WAIT as success, or that leaked stale read data. A `start` pulse in the middle of a transfer must leave the waveform untouched.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LRST_HI,
    ST_LRST_LO,
    ST_REQ,
    ST_TRN_A,
    ST_ACK,
    ST_TRN_W,
    ST_WDATA,
    ST_RDATA,
    ST_TRN_B
  } seq_state_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int REQ_BITS  = 8;
  localparam int DATA_BITS = 33;

endpackage

// File: rtl/swd_host_clkgen.sv
module swd_host_clkgen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(CLK_HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign swclk    = ph_q;
  assign rise_evt = run & wrap & ~ph_q;
  assign fall_evt = run & wrap & ph_q;

endmodule

// File: rtl/swd_host_reqgen.sv
module swd_host_reqgen (
  input  logic       sel_ap,
  input  logic       is_read,
  input  logic [1:0] addr,
  output logic [7:0] frame
);

  logic par;

  assign par   = sel_ap ^ is_read ^ addr[0] ^ addr[1];
  assign frame = {1'b1, 1'b0, par, addr[1], addr[0], is_read, sel_ap, 1'b1};

endmodule

// File: rtl/swd_host_drive.sv
module swd_host_drive
  import swd_host_pkg::*;
(
  input  seq_state_t state,
  input  logic [2:0] req_idx,
  input  logic [7:0] frame,
  input  logic       wbit,
  output logic       oe,
  output logic       out
);

  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    unique case (state)
      ST_IDLE: begin
        oe  = 1'b1;
        out = 1'b0;
      end
      ST_LRST_HI: begin
        oe  = 1'b1;
        out = 1'b1;
      end
      ST_LRST_LO: begin
        oe  = 1'b1;
        out = 1'b0;
      end
      ST_REQ: begin
        oe  = (req_idx != 3'd7);
        out = frame[req_idx];
      end
      ST_WDATA: begin
        oe  = 1'b1;
        out = wbit;
      end
      default: begin
        oe  = 1'b0;
        out = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_host_pkg::*;
#(
  parameter int CLK_HALF   = 2,
  parameter int RETRY_MAX  = 3,
  parameter int LRST_HIGH  = 50,
  parameter int LRST_LOW   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cmd_ap,
  input  logic        cmd_read,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  input  logic        cmd_line_reset,
  output logic        busy,
  output logic        done,
  output logic [2:0]  done_ack,
  output logic [31:0] done_rdata,
  output logic        done_perr,
  output logic        swclk,
  input  logic        swdio_in,
  output logic        swdio_out,
  output logic        swdio_oe
);

  localparam int CNT_A   = (LRST_HIGH > DATA_BITS) ? LRST_HIGH : DATA_BITS;
  localparam int CNT_TOP = (LRST_LOW > CNT_A) ? LRST_LOW : CNT_A;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam int RW      = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [RW-1:0]     retry_q, retry_d;
  logic              ap_q, ap_d, rd_q, rd_d;
  logic [1:0]        addr_q, addr_d;
  logic [31:0]       wdata_q, wdata_d;
  logic [32:0]       dsh_q, dsh_d;
  logic [2:0]        ack_q, ack_d;
  logic              done_q, done_d;
  logic [2:0]        rack_q, rack_d;
  logic [31:0]       rdata_q, rdata_d;
  logic              rperr_q, rperr_d;
  logic              finish, read_ok;
  logic              run, rise_evt, fall_evt;
  logic [7:0]        frame;

  assign run = (state_q != ST_IDLE);

  swd_host_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run),
    .swclk    (swclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  swd_host_reqgen u_req (
    .sel_ap  (ap_q),
    .is_read (rd_q),
    .addr    (addr_q),
    .frame   (frame)
  );

  swd_host_drive u_drv (
    .state   (state_q),
    .req_idx (bcnt_q[2:0]),
    .frame   (frame),
    .wbit    (dsh_q[0]),
    .oe      (swdio_oe),
    .out     (swdio_out)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    retry_d = retry_q;
    ap_d    = ap_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    dsh_d   = dsh_q;
    ack_d   = ack_q;
    rack_d  = rack_q;
    rdata_d = rdata_q;
    rperr_d = rperr_q;
    done_d  = 1'b0;
    finish  = 1'b0;
    read_ok = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          bcnt_d = '0;
          if (cmd_line_reset) begin
            state_d = ST_LRST_HI;
            rd_d    = 1'b0;
            ack_d   = 3'b000;
          end else begin
            state_d = ST_REQ;
            ap_d    = cmd_ap;
            rd_d    = cmd_read;
            addr_d  = cmd_addr;
            wdata_d = cmd_wdata;
            retry_d = '0;
            dsh_d   = '0;
          end
        end
      end

      ST_LRST_HI: begin
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(LRST_HIGH - 1)) begin
            state_d = ST_LRST_LO;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end

      ST_LRST_LO: begin
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(LRST_LOW - 1)) finish = 1'b1;
          else                                bcnt_d = bcnt_q + CNT_W'(1);
        end
      end

      ST_REQ: begin
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(REQ_BITS - 1)) begin
            state_d = ST_TRN_A;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end

      ST_TRN_A: begin
        if (fall_evt) begin
          state_d = ST_ACK;
          bcnt_d  = '0;
        end
      end

      ST_ACK: begin
        if (rise_evt) ack_d = {swdio_in, ack_q[2:1]};
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(2)) begin
            bcnt_d = '0;
            if (ack_q == ACK_OK) state_d = rd_q ? ST_RDATA : ST_TRN_W;
            else                 state_d = ST_TRN_B;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end

      ST_TRN_W: begin
        if (fall_evt) begin
          state_d = ST_WDATA;
          bcnt_d  = '0;
          dsh_d   = {^wdata_q, wdata_q};
        end
      end

      ST_WDATA: begin
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(DATA_BITS - 1)) begin
            finish = 1'b1;
          end else begin
            dsh_d  = {1'b0, dsh_q[32:1]};
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end

      ST_RDATA: begin
        if (rise_evt) dsh_d = {swdio_in, dsh_q[32:1]};
        if (fall_evt) begin
          if (bcnt_q == CNT_W'(DATA_BITS - 1)) begin
            state_d = ST_TRN_B;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end

      ST_TRN_B: begin
        if (fall_evt) begin
          if ((ack_q == ACK_WAIT) && (retry_q < RW'(RETRY_MAX))) begin
            retry_d = retry_q + RW'(1);
            state_d = ST_REQ;
            bcnt_d  = '0;
            dsh_d   = '0;
          end else begin
            finish = 1'b1;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase

    if (finish) begin
      read_ok = rd_q && (ack_q == ACK_OK);
      state_d = ST_IDLE;
      done_d  = 1'b1;
      rack_d  = ack_q;
      rdata_d = read_ok ? dsh_q[31:0] : 32'h0;
      rperr_d = read_ok && ((^dsh_q[31:0]) != dsh_q[32]);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      retry_q <= '0;
      ap_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= 2'b00;
      wdata_q <= '0;
      dsh_q   <= '0;
      ack_q   <= 3'b000;
      done_q  <= 1'b0;
      rack_q  <= 3'b000;
      rdata_q <= '0;
      rperr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      retry_q <= retry_d;
      ap_q    <= ap_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      dsh_q   <= dsh_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      rack_q  <= rack_d;
      rdata_q <= rdata_d;
      rperr_q <= rperr_d;
    end
  end

  assign busy       = run;
  assign done       = done_q;
  assign done_ack   = rack_q;
  assign done_rdata = rdata_q;
  assign done_perr  = rperr_q;

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [2:0]  done_ack,
  input logic [31:0] done_rdata,
  input logic        done_perr,
  input logic        swclk,
  input logic        swdio_out,
  input logic        swdio_oe
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swdio_oe && !swdio_out && !swclk));  // R10

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R10

  AST_DRIVE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ((swdio_out != $past(swdio_out)) || (swdio_oe != $past(swdio_oe))) |-> !swclk);  // R8

  AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> busy);  // R8

  AST_PERR_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_perr) |-> (done_ack == 3'b001));  // R5

  AST_RDATA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_ack != 3'b001)) |-> (done_rdata == 32'h0));  // R7

endmodule

bind swd_host swd_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .done_ack   (done_ack),
  .done_rdata (done_rdata),
  .done_perr  (done_perr),
  .swclk      (swclk),
  .swdio_out  (swdio_out),
  .swdio_oe   (swdio_oe)
);

// File: tb/sim_swd_host.sv
module sim_swd_host;

  localparam int HALF  = 2;
  localparam int RETRY = 3;
  localparam int LHI   = 50;
  localparam int LLO   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        start, cmd_ap, cmd_read, cmd_line_reset;
  logic [1:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic        swdio_in;
  logic        busy, done, done_perr, swclk, swdio_out, swdio_oe;
  logic [2:0]  done_ack;
  logic [31:0] done_rdata;

  swd_host #(.CLK_HALF(HALF), .RETRY_MAX(RETRY), .LRST_HIGH(LHI), .LRST_LOW(LLO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ap(cmd_ap), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_line_reset(cmd_line_reset),
    .busy(busy), .done(done), .done_ack(done_ack), .done_rdata(done_rdata),
    .done_perr(done_perr), .swclk(swclk), .swdio_in(swdio_in),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe)
  );

  int checks = 0;
  int fails  = 0;

  bit    q_oe[$];
  bit    q_out[$];
  bit    q_tgt[$];
  string q_tag[$];
  logic [2:0] ack_script[$];

  logic [2:0]  e_ack;
  logic [31:0] e_rdata;
  bit          e_perr;
  string       e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit oe, input bit out, input bit tgt, input string tag);
    q_oe.push_back(oe);
    q_out.push_back(out);
    q_tgt.push_back(tgt);
    q_tag.push_back(tag);
  endtask

  // reference model of one command: expected line per bit period
  task automatic build(input bit ap, input bit rd, input logic [1:0] addr,
                       input logic [31:0] wd, input logic [31:0] rv, input bit badp);
    logic [2:0] a;
    int att;
    att = 0;
    forever begin
      a = (att < ack_script.size()) ? ack_script[att] : ack_script[ack_script.size()-1];
      push(1, 1, 1, "R1");
      push(1, ap, 1, "R1");
      push(1, rd, 1, "R1");
      push(1, addr[0], 1, "R1");
      push(1, addr[1], 1, "R1");
      push(1, ap ^ rd ^ addr[0] ^ addr[1], 1, "R1");
      push(1, 0, 1, "R1");
      push(0, 0, 1, "R1");
      push(0, 0, 1, "R2");
      for (int i = 0; i < 3; i++) push(0, 0, a[i], "R2");
      if (a == 3'b001) begin
        if (!rd) begin
          push(0, 0, 1, "R3");
          for (int i = 0; i < 32; i++) push(1, wd[i], 1, "R3");
          push(1, ^wd, 1, "R3");
        end else begin
          for (int i = 0; i < 32; i++) push(0, 0, rv[i], "R4");
          push(0, 0, (^rv) ^ badp, "R4");
          push(0, 0, 1, "R4");
        end
      end else begin
        push(0, 0, 1, (a == 3'b010) ? "R6" : "R7");
      end
      if (a != 3'b010 || att == RETRY) break;
      att++;
    end
    e_ack   = a;
    e_rdata = (rd && a == 3'b001) ? rv : 32'h0;
    e_perr  = rd && (a == 3'b001) && badp;
    if (a == 3'b001) e_tag = rd ? (badp ? "R5" : "R4") : "R3";
    else             e_tag = (a == 3'b010) ? "R6" : "R7";
  endtask

  task automatic build_lrst();
    for (int i = 0; i < LHI; i++) push(1, 1, 1, "R9");
    for (int i = 0; i < LLO; i++) push(1, 0, 1, "R9");
    e_ack = 3'b000; e_rdata = 32'h0; e_perr = 1'b0; e_tag = "R9";
  endtask

  task automatic play(input bit ap, input bit rd, input logic [1:0] addr,
                      input logic [31:0] wd, input bit lrst, input int poke);
    @(negedge clk);
    cmd_ap = ap; cmd_read = rd; cmd_addr = addr; cmd_wdata = wd;
    cmd_line_reset = lrst; start = 1'b1; swdio_in = 1'b1;
    @(negedge clk);
    for (int b = 0; b < q_oe.size(); b++) begin
      for (int h = 0; h < 2*HALF; h++) begin
        start = (b == poke) && (h == 0);   // R10: ignored while busy
        cmd_line_reset = start ? 1'b1 : lrst;
        if (h == 0) swdio_in = q_tgt[b];
        chk(swclk == (h >= HALF), "R8", "swclk", {31'd0, swclk}, {31'd0, (h >= HALF)});
        chk(busy && (swdio_oe == q_oe[b]) && (!q_oe[b] || swdio_out == q_out[b]),
            q_tag[b], "line busy/oe/out",
            {29'd0, busy, swdio_oe, swdio_out}, {29'd0, 1'b1, q_oe[b], q_out[b]});
        @(negedge clk);
      end
    end
    start = 1'b0; swdio_in = 1'b1; cmd_line_reset = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R10", "done strobe", {30'd0, done, busy}, 32'h2);
    chk(done_ack == e_ack, e_tag, "ack", {29'd0, done_ack}, {29'd0, e_ack});
    chk(done_rdata == e_rdata, e_tag, "rdata", done_rdata, e_rdata);
    chk(done_perr == e_perr, e_tag, "perr", {31'd0, done_perr}, {31'd0, e_perr});
    @(negedge clk);
    chk(!done && !busy && swdio_oe && !swdio_out && !swclk, "R10", "idle after done",
        {27'd0, done, busy, swdio_oe, swdio_out, swclk}, 32'h4);
    q_oe.delete(); q_out.delete(); q_tgt.delete(); q_tag.delete();
    ack_script.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_ap = 1'b0; cmd_read = 1'b0; cmd_addr = 2'b00;
    cmd_wdata = 32'h0; cmd_line_reset = 1'b0; swdio_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && swdio_oe && !swdio_out && !swclk, "R10", "reset state",
        {27'd0, busy, done, swdio_oe, swdio_out, swclk}, 32'h4);

    // R3 write OK, debug port, addr 1
    ack_script.push_back(3'b001);
    build(0, 0, 2'd1, 32'hA5A5_0F3C, 32'h0, 0);
    play(0, 0, 2'd1, 32'hA5A5_0F3C, 0, -1);

    // R4 read OK, access port, addr 3, with a start poke mid-request (R10)
    ack_script.push_back(3'b001);
    build(1, 1, 2'd3, 32'h0, 32'h1234_5678, 0);
    play(1, 1, 2'd3, 32'h0, 0, 3);

    // R5 read OK with corrupted parity
    ack_script.push_back(3'b001);
    build(0, 1, 2'd2, 32'h0, 32'hFFFF_0001, 1);
    play(0, 1, 2'd2, 32'h0, 0, -1);

    // R6 write: WAIT then OK
    ack_script.push_back(3'b010);
    ack_script.push_back(3'b001);
    build(1, 0, 2'd0, 32'h8000_0001, 32'h0, 0);
    play(1, 0, 2'd0, 32'h8000_0001, 0, -1);

    // R6 read: WAIT forever, retries exhausted
    ack_script.push_back(3'b010);
    build(1, 1, 2'd1, 32'h0, 32'hDEAD_BEEF, 0);
    play(1, 1, 2'd1, 32'h0, 0, -1);

    // R7 write with FAULT
    ack_script.push_back(3'b100);
    build(0, 0, 2'd3, 32'h1111_2222, 32'h0, 0);
    play(0, 0, 2'd3, 32'h1111_2222, 0, -1);

    // R7 read with invalid codes
    ack_script.push_back(3'b111);
    build(1, 1, 2'd2, 32'h0, 32'h5555_AAAA, 0);
    play(1, 1, 2'd2, 32'h0, 0, -1);
    ack_script.push_back(3'b000);
    build(0, 1, 2'd0, 32'h0, 32'h0F0F_0F0F, 0);
    play(0, 1, 2'd0, 32'h0, 0, -1);

    // R9 line reset
    build_lrst();
    play(0, 0, 2'd0, 32'h0, 1, -1);

    // R4 read after line reset, odd-weight word
    ack_script.push_back(3'b001);
    build(0, 1, 2'd1, 32'h0, 32'h0000_0007, 0);
    play(0, 1, 2'd1, 32'h0, 0, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule